// File: doc/BRIEF.md
# Latched Input Transition Detector

This block watches a bank of port pins on behalf of a serial port expander. Each pin that is currently released by its open-drain output latch counts as an input. The block keeps a snapshot of those inputs. Any difference between a synchronized input and its snapshot bit sets a sticky per-pin transition flag and drives an active-low interrupt line through an open-drain enable. The flags are sticky, so a pulse that returns to its old level before the master looks is still reported.

The serial engine in front of the block supplies three signals. `addr_ack` is a one-cycle strobe at the acknowledge of the block's own slave address. `stop_seen` is a one-cycle strobe at the bus STOP. `rd_active` is the direction of the access, valid together with `addr_ack`. At every address acknowledge the block does four things: it hands the accumulated flags to the serial engine (on reads only), retakes the snapshot, clears the flags and releases the interrupt. While the access is open the interrupt stays released. Changes during the access are still flagged, and the interrupt is driven again when STOP arrives.

A pin whose output latch bit is 0 is driven low by the expander and is never reported. When a latch bit changes, the pin level that follows from the write is absorbed into the snapshot during a short settle window and is not reported. The flag byte reaches the serial engine over a valid/ready pair. `flag_data` is held stable while `flag_valid` is high and `flag_ready` is low. The byte is consumed in the cycle where both are high. A new read acknowledge replaces any byte that has not been taken.

Top module: `port_change_monitor`

## Requirements
- R1: When no access is open, a pin with `out_latch` bit 1 whose level differs from its snapshot sets its flag, and `irq_n_oe` goes to 1 within 4 clock cycles of the pin change.
- R2: Flags are sticky. A pin pulse that returns to its previous level before the next address acknowledge is still reported in the flag byte and keeps `irq_n_oe` at 1.
- R3: On the cycle after `addr_ack`, `irq_n_oe` is 0 and all flags are clear. The snapshot then equals the current pin levels, so a pin that stays at its new level raises no new flag.
- R4: From `addr_ack` until `stop_seen`, `irq_n_oe` stays 0. On the cycle after `stop_seen`, `irq_n_oe` is 1 if any flag was set during the access and stays 0 otherwise.
- R5: A pin whose `out_latch` bit is 0 never sets its flag. A pin change caused by a change of its `out_latch` bit, and arriving within SETTLE_CYC cycles of that change, is not reported.
- R6: On the cycle after `addr_ack` with `rd_active`=1, `flag_valid` is 1 and `flag_data` holds the flags accumulated before that acknowledge. `addr_ack` with `rd_active`=0 does not raise `flag_valid`.
- R7: While `flag_valid`=1 and `flag_ready`=0, `flag_data` and `flag_valid` hold. After a cycle with both at 1, `flag_valid` is 0.
- R8: Bit i of `flag_data` reports pin `port_in[i]`. Bit 0 is the lowest pin.
- R9: After `rst_n` is released, `irq_n_oe` and `flag_valid` are 0, and pins that are already high at reset are not reported in the first flag byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-up reset, active low |
| port_in | input | PORT_W | Asynchronous pin levels |
| out_latch | input | PORT_W | Open-drain output latch; 1 releases the pin and makes it an input |
| addr_ack | input | 1 | Strobe at the acknowledge of this block's slave address |
| stop_seen | input | 1 | Strobe at the bus STOP condition |
| rd_active | input | 1 | Access direction at `addr_ack`; 1 for read |
| flag_data | output | PORT_W | Flag byte for the serial engine |
| flag_valid | output | 1 | `flag_data` is offered |
| flag_ready | input | 1 | Serial engine takes the flag byte |
| irq_n_oe | output | 1 | 1 pulls the shared interrupt line low |

## Verification
A wrong snapshot or flag register appears as a wrong `flag_data` bit at the next read acknowledge. A wrong access state appears as `irq_n_oe` asserted inside an access, or as an interrupt missing on the cycle after STOP. Both are visible within one cycle of the strobe involved. A pin change that is dropped or invented appears on `irq_n_oe` within four cycles, because the synchronizer adds two cycles and the flag adds one. A settle window that is too short shows up as a spurious interrupt right after an output-latch change.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  // Minimum synchronizer depth accepted by the monitor
  localparam int unsigned PCM_MIN_SYNC = 2;

  typedef enum logic {
    ACC_IDLE = 1'b0,
    ACC_OPEN = 1'b1
  } acc_state_e;
endpackage

// File: rtl/pcm_sync.sv
module pcm_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/pcm_quiet_window.sv
module pcm_quiet_window #(
  parameter int unsigned W      = 8,
  parameter int unsigned SETTLE = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] out_latch,
  output logic [W-1:0] quiet
);
  localparam int unsigned CW = $clog2(SETTLE + 1);

  logic [W-1:0]  latch_q;
  logic [W-1:0]  win_mask;
  logic [CW-1:0] cnt;
  logic [W-1:0]  diff;
  logic          win_open;

  assign diff     = out_latch ^ latch_q;
  assign win_open = (cnt != '0);

  // After reset every pin is absorbed into the snapshot for SETTLE cycles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q  <= '1;
      cnt      <= CW'(SETTLE);
      win_mask <= '1;
    end else begin
      latch_q <= out_latch;
      if (|diff) begin
        cnt      <= CW'(SETTLE);
        win_mask <= (win_open ? win_mask : '0) | diff;
      end else if (win_open) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign quiet = ~out_latch | diff | (win_open ? win_mask : '0);

  AST_WINDOW_COVERS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (|diff) |=> ((quiet & $past(diff)) == $past(diff))) else $error("window"); // R5
endmodule

// File: rtl/pcm_flag_bank.sv
module pcm_flag_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sampled,
  input  logic [W-1:0] quiet,
  input  logic         take_snap,
  output logic [W-1:0] flags
);
  logic [W-1:0] snap_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        snap_q[i] <= 1'b0;
        flags[i]  <= 1'b0;
      end else if (take_snap) begin
        snap_q[i] <= sampled[i];
        flags[i]  <= 1'b0;
      end else if (quiet[i]) begin
        snap_q[i] <= sampled[i];
      end else if (sampled[i] != snap_q[i]) begin
        flags[i] <= 1'b1;
      end
    end
  end

  AST_CLEAR_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    take_snap |=> (flags == '0)) else $error("clear"); // R3
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !take_snap |=> ((flags & $past(flags)) == $past(flags))) else $error("sticky"); // R2
  AST_QUIET_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(flags) & $past(quiet)) == '0)) else $error("quiet"); // R5
endmodule

// File: rtl/pcm_readback.sv
module pcm_readback #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         ready,
  output logic [W-1:0] data,
  output logic         valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data  <= '0;
      valid <= 1'b0;
    end else if (load) begin
      data  <= load_data;
      valid <= 1'b1;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !load) |=> (valid && $stable(data))) else $error("hold"); // R7
  AST_TAKEN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready && !load) |=> !valid) else $error("drop"); // R7
endmodule

// File: rtl/port_change_monitor.sv
module port_change_monitor #(
  parameter int unsigned PORT_W     = 8,
  parameter int unsigned SYNC_DEPTH = 2,
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] port_in,
  input  logic [PORT_W-1:0] out_latch,
  input  logic              addr_ack,
  input  logic              stop_seen,
  input  logic              rd_active,
  output logic [PORT_W-1:0] flag_data,
  output logic              flag_valid,
  input  logic              flag_ready,
  output logic              irq_n_oe
);
  import pcm_pkg::*;

  localparam int unsigned SYNC_USED = (SYNC_DEPTH < PCM_MIN_SYNC) ? PCM_MIN_SYNC : SYNC_DEPTH;

  logic [PORT_W-1:0] sampled;
  logic [PORT_W-1:0] quiet;
  logic [PORT_W-1:0] flags;
  acc_state_e        acc_q;

  pcm_sync #(.W(PORT_W), .STAGES(SYNC_USED)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(port_in), .dout(sampled)
  );

  pcm_quiet_window #(.W(PORT_W), .SETTLE(SETTLE_CYC)) u_quiet (
    .clk(clk), .rst_n(rst_n), .out_latch(out_latch), .quiet(quiet)
  );

  pcm_flag_bank #(.W(PORT_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .sampled(sampled), .quiet(quiet),
    .take_snap(addr_ack), .flags(flags)
  );

  pcm_readback #(.W(PORT_W)) u_rdbk (
    .clk(clk), .rst_n(rst_n), .load(addr_ack && rd_active), .load_data(flags),
    .ready(flag_ready), .data(flag_data), .valid(flag_valid)
  );

  // An acknowledge opens an access; STOP closes it (acknowledge wins a tie)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         acc_q <= ACC_IDLE;
    else if (addr_ack)  acc_q <= ACC_OPEN;
    else if (stop_seen) acc_q <= ACC_IDLE;
  end

  assign irq_n_oe = (|flags) && (acc_q == ACC_IDLE);

  AST_ACK_RELEASES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ack |=> !irq_n_oe) else $error("ack irq"); // R3
  AST_IRQ_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_seen && !addr_ack && (|flags)) |=> irq_n_oe) else $error("stop irq"); // R4
  AST_READ_OFFERS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_ack && rd_active) |=> (flag_valid && flag_data == $past(flags))) else $error("read"); // R6
  AST_OPEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q == ACC_OPEN) |-> !irq_n_oe) else $error("open"); // R4
endmodule

// File: tb/port_change_monitor_tb_top.sv
`timescale 1ns/1ps
module port_change_monitor_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] ext_drv = '1;
  logic [W-1:0] out_latch = '1;
  logic         addr_ack = 1'b0;
  logic         stop_seen = 1'b0;
  logic         rd_active = 1'b0;
  logic         flag_ready = 1'b0;
  logic [W-1:0] flag_data;
  logic         flag_valid;
  logic         irq_n_oe;
  logic [W-1:0] pins;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // Open-drain pin: low when latch drives it or the external source pulls it
  assign pins = out_latch & ext_drv;

  port_change_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .port_in(pins), .out_latch(out_latch),
    .addr_ack(addr_ack), .stop_seen(stop_seen), .rd_active(rd_active),
    .flag_data(flag_data), .flag_valid(flag_valid), .flag_ready(flag_ready),
    .irq_n_oe(irq_n_oe)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ack(input logic rd);
    rd_active = rd; addr_ack = 1'b1;
    step(1);
    addr_ack = 1'b0; rd_active = 1'b0;
  endtask

  task automatic stop();
    stop_seen = 1'b1;
    step(1);
    stop_seen = 1'b0;
  endtask

  // Full read: returns flag byte, takes it, closes with STOP
  task automatic read_flags(output logic [W-1:0] got);
    ack(1'b1);
    got = flag_data;
    flag_ready = 1'b1;
    step(1);
    flag_ready = 1'b0;
    stop();
  endtask

  task automatic t_reset();
    logic [W-1:0] got;
    step(3); rst_n = 1'b1; step(8);
    chk("R9 irq after reset", W'(irq_n_oe), 8'h00);
    chk("R9 valid after reset", W'(flag_valid), 8'h00);
    read_flags(got);
    chk("R9 first flag byte", got, 8'h00);
  endtask

  task automatic t_detect();
    logic [W-1:0] got;
    ext_drv[3] = 1'b0; step(4);
    chk("R1 irq on change", W'(irq_n_oe), 8'h01);
    ack(1'b1);
    chk("R3 irq released at ack", W'(irq_n_oe), 8'h00);
    chk("R6 valid on read ack", W'(flag_valid), 8'h01);
    chk("R8 bit 3 reported", flag_data, 8'h08);
    flag_ready = 1'b1; step(1); flag_ready = 1'b0;
    chk("R7 valid dropped after take", W'(flag_valid), 8'h00);
    stop(); step(4);
    chk("R3 held level not reflagged", W'(irq_n_oe), 8'h00);
    ext_drv[3] = 1'b1; step(4);
    read_flags(got);
    chk("R8 bit 3 again", got, 8'h08);
  endtask

  task automatic t_glitch();
    logic [W-1:0] got;
    ext_drv[5] = 1'b0; step(1); ext_drv[5] = 1'b1; step(5);
    chk("R2 pulse keeps irq", W'(irq_n_oe), 8'h01);
    read_flags(got);
    chk("R2 pulse in flag byte", got, 8'h20);
  endtask

  task automatic t_hold();
    logic [W-1:0] got;
    ack(1'b0);
    chk("R6 write ack no valid", W'(flag_valid), 8'h00);
    ext_drv[0] = 1'b0; step(5);
    chk("R4 irq held during access", W'(irq_n_oe), 8'h00);
    stop();
    chk("R4 irq after stop", W'(irq_n_oe), 8'h01);
    read_flags(got);
    chk("R4 change in access flagged", got, 8'h01);
    ack(1'b0); stop(); step(2);
    chk("R4 quiet stop no irq", W'(irq_n_oe), 8'h00);
    ext_drv[0] = 1'b1; step(4); read_flags(got);
  endtask

  task automatic t_latch();
    logic [W-1:0] got;
    out_latch[6] = 1'b0; step(6);
    chk("R5 latch low no irq", W'(irq_n_oe), 8'h00);
    ext_drv[6] = 1'b0; step(2); ext_drv[6] = 1'b1; step(4);
    chk("R5 driven pin ignored", W'(irq_n_oe), 8'h00);
    out_latch[6] = 1'b1; step(6);
    chk("R5 latch release no irq", W'(irq_n_oe), 8'h00);
    read_flags(got);
    chk("R5 no flag from latch", got, 8'h00);
  endtask

  task automatic t_stall();
    logic [W-1:0] got;
    ext_drv[7] = 1'b0; ext_drv[1] = 1'b0; step(5);
    ack(1'b1);
    step(3);
    chk("R7 valid held", W'(flag_valid), 8'h01);
    chk("R7 data held", flag_data, 8'h82);
    flag_ready = 1'b1; step(1); flag_ready = 1'b0;
    chk("R7 dropped", W'(flag_valid), 8'h00);
    stop();
    ext_drv[7] = 1'b1; ext_drv[1] = 1'b1; step(5);
    read_flags(got);
    chk("R8 bits 7 and 1", got, 8'h82);
  endtask

  initial begin
    t_reset();
    t_detect();
    t_glitch();
    t_hold();
    t_latch();
    t_stall();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule